// File: doc/BRIEF.md
# Paged Receive Ring Buffer Manager

This block places incoming frames into a circular receive area inside a packet RAM that is organised as 256-byte pages. Software defines the ring with a first page and an end page (the end page itself is never used), and a boundary page that marks the oldest page the host has not yet consumed. The block owns a current-page pointer that names the page where the next frame will land.

Each accepted frame is written starting at offset 4 of the current page and continues page by page, wrapping from the end page back to the first page. Once the last byte has been stored and the frame is reported good, the block goes back and fills in the four header bytes at offsets 0 to 3 of the frame's first page: the receive status, the page where the following frame will start, and a 16-bit byte count. Only then does the current pointer move. Before claiming any new page, whether mid-frame or as the start page for the next frame, the block compares that page against the boundary page. A match aborts the frame, leaves the current pointer alone and halts reception until the host moves the boundary. A monitor mode checks frames without storing them.

The sender must leave at least four idle cycles after each end-of-frame so that the header can be written. Bytes offered during those cycles are not taken.

Top module: `rxring_mgr`

## Requirements
- R1: After reset the register map reads: address 0 first page = 0x46, address 1 end page = 0x80, address 2 boundary = 0x46, address 3 current page = 0x47, address 4 control = 0x00, address 5 status = 0x00, address 6 missed count = 0x00. Address 7 reads 0.
- R2: The first byte of a stored frame is written to offset 4 of the current page. Each further byte goes to the next offset, and after offset 255 it goes to offset 0 of the next page. The RAM address is {page, offset}.
- R3: The page that follows end page minus one is the first page.
- R4: After the last byte of a good frame (status input bit 0 = 1), four writes go to offsets 0, 1, 2 and 3 of the frame's first page, after all data writes. They carry, in that order: the status sampled with the last byte, the next page, the low byte of (frame length + 4), and the high byte of (frame length + 4).
- R5: When a good frame is stored, the current page becomes the page that follows the page holding the frame's last byte, and status bit 0 (stored) is set.
- R6: A frame whose status bit 0 is 0 gets no header, and the current page is left unchanged.
- R7: If the page about to be claimed (a new page mid-frame, or the next page at frame end) equals the boundary, the frame is aborted and the rest of its bytes are not written. Status bits 1 (missed), 2 (overwrite) and 3 (halted) are set, the missed count increases by 1, and the current page is unchanged.
- R8: While status bit 3 is set, frames cause no RAM writes and each one increases the missed count. Writing the boundary register with a value different from its present one clears bit 3.
- R9: With control bit 0 (monitor) set, frames cause no RAM writes and each one increases the missed count.
- R10: Writing 1 to status bits 0 to 2 clears them. Any write to address 6 clears the missed count, which saturates at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| rx_valid | input | 1 | Frame byte present |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Byte is the last of its frame |
| rx_status | input | 8 | Receive status, valid with rx_last; bit 0 = good |
| ram_we | output | 1 | Packet RAM write enable |
| ram_addr | output | 16 | Packet RAM byte address {page, offset} |
| ram_wdata | output | 8 | Packet RAM write data |

## Verification
The bench sends frames that cross pages and wrap from the end page back to the first page. A design that forgot the wrap would write outside the ring and give a wrong next-page header byte. It also drives overflow in both places where it can happen: at frame end, where the next page equals the boundary, and mid-frame, where a page is claimed. A design that checked only one of these would store over unread data or move the current pointer. Bad frames, halted reception, monitor mode and count saturation are each checked at the RAM port and through register reads. A wrong design would show stray header writes, a moved pointer, or a missed count that is off by one or has wrapped.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
    localparam int DW        = 8;
    localparam int HDR_BYTES = 4;

    localparam logic [2:0] A_FIRST = 3'd0;
    localparam logic [2:0] A_END   = 3'd1;
    localparam logic [2:0] A_BNDRY = 3'd2;
    localparam logic [2:0] A_CURR  = 3'd3;
    localparam logic [2:0] A_CTRL  = 3'd4;
    localparam logic [2:0] A_STAT  = 3'd5;
    localparam logic [2:0] A_MISS  = 3'd6;

    typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_DROP, ST_HDR} fsm_e;
endpackage

// File: rtl/rxr_page_adv.sv
module rxr_page_adv #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] cur,
    input  logic [PAGE_W-1:0] first,
    input  logic [PAGE_W-1:0] last_excl,
    output logic [PAGE_W-1:0] nxt
);
    logic [PAGE_W-1:0] inc;
    always_comb begin
        inc = cur + 1'b1;
        nxt = (inc == last_excl) ? first : inc;
    end
endmodule

// File: rtl/rxr_regs.sv
module rxr_regs
    import rxr_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int MISS_W = 8,
    parameter logic [PAGE_W-1:0] FIRST_RST = 8'h46,
    parameter logic [PAGE_W-1:0] END_RST   = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic              ev_stored,
    input  logic              ev_missed,
    input  logic              ev_ovw,
    input  logic              curr_ld,
    input  logic [PAGE_W-1:0] curr_nx,
    output logic [PAGE_W-1:0] first_o,
    output logic [PAGE_W-1:0] end_o,
    output logic [PAGE_W-1:0] bndry_o,
    output logic [PAGE_W-1:0] curr_o,
    output logic              mon_o,
    output logic [3:0]        flags_o,
    output logic [MISS_W-1:0] miss_o
);
    localparam logic [MISS_W-1:0] MISS_MAX = '1;

    typedef struct packed {
        logic [PAGE_W-1:0] first;
        logic [PAGE_W-1:0] last_excl;
        logic [PAGE_W-1:0] bndry;
        logic [PAGE_W-1:0] curr;
        logic              mon;
        logic              f_stored;
        logic              f_missed;
        logic              f_ovw;
        logic              halted;
        logic [MISS_W-1:0] miss;
    } regs_t;

    regs_t r_d, r_q;
    logic  wr_bndry, wr_stat, wr_miss;
    logic  any_miss;

    always_comb begin
        r_d      = r_q;
        wr_bndry = reg_wr && (reg_addr == A_BNDRY);
        wr_stat  = reg_wr && (reg_addr == A_STAT);
        wr_miss  = reg_wr && (reg_addr == A_MISS);
        any_miss = ev_missed || ev_ovw;

        if (reg_wr && reg_addr == A_FIRST) r_d.first     = reg_wdata[PAGE_W-1:0];
        if (reg_wr && reg_addr == A_END)   r_d.last_excl = reg_wdata[PAGE_W-1:0];
        if (reg_wr && reg_addr == A_CTRL)  r_d.mon       = reg_wdata[0];
        if (wr_bndry) begin
            r_d.bndry = reg_wdata[PAGE_W-1:0];
            if (reg_wdata[PAGE_W-1:0] != r_q.bndry) r_d.halted = 1'b0;
        end
        if (reg_wr && reg_addr == A_CURR) r_d.curr = reg_wdata[PAGE_W-1:0];
        if (curr_ld)                      r_d.curr = curr_nx;

        if (wr_stat) begin
            if (reg_wdata[0]) r_d.f_stored = 1'b0;
            if (reg_wdata[1]) r_d.f_missed = 1'b0;
            if (reg_wdata[2]) r_d.f_ovw    = 1'b0;
        end
        if (ev_stored) r_d.f_stored = 1'b1;
        if (any_miss)  r_d.f_missed = 1'b1;
        if (ev_ovw) begin
            r_d.f_ovw  = 1'b1;
            r_d.halted = 1'b1;
        end

        if (wr_miss) r_d.miss = '0;
        if (any_miss && r_d.miss != MISS_MAX) r_d.miss = r_d.miss + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.first     <= FIRST_RST;
            r_q.last_excl <= END_RST;
            r_q.bndry     <= FIRST_RST;
            r_q.curr      <= FIRST_RST + 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (reg_addr)
            A_FIRST: reg_rdata = DW'(r_q.first);
            A_END:   reg_rdata = DW'(r_q.last_excl);
            A_BNDRY: reg_rdata = DW'(r_q.bndry);
            A_CURR:  reg_rdata = DW'(r_q.curr);
            A_CTRL:  reg_rdata = DW'(r_q.mon);
            A_STAT:  reg_rdata = DW'({r_q.halted, r_q.f_ovw, r_q.f_missed, r_q.f_stored});
            A_MISS:  reg_rdata = DW'(r_q.miss);
            default: reg_rdata = '0;
        endcase
    end

    assign first_o = r_q.first;
    assign end_o   = r_q.last_excl;
    assign bndry_o = r_q.bndry;
    assign curr_o  = r_q.curr;
    assign mon_o   = r_q.mon;
    assign flags_o = {r_q.halted, r_q.f_ovw, r_q.f_missed, r_q.f_stored};
    assign miss_o  = r_q.miss;
endmodule

// File: rtl/rxr_frame.sv
module rxr_frame
    import rxr_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 8,
    parameter int LEN_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic [DW-1:0]           rx_data,
    input  logic                    rx_last,
    input  logic [DW-1:0]           rx_status,
    input  logic [PAGE_W-1:0]       first,
    input  logic [PAGE_W-1:0]       last_excl,
    input  logic [PAGE_W-1:0]       bndry,
    input  logic [PAGE_W-1:0]       curr,
    input  logic                    mon,
    input  logic                    halted,
    output logic                    ram_we,
    output logic [PAGE_W+OFF_W-1:0] ram_addr,
    output logic [DW-1:0]           ram_wdata,
    output logic                    ev_stored,
    output logic                    ev_missed,
    output logic                    ev_ovw,
    output logic                    curr_ld,
    output logic [PAGE_W-1:0]       curr_nx
);
    localparam int ADDR_W = PAGE_W + OFF_W;
    localparam logic [OFF_W-1:0] DATA_OFF = OFF_W'(HDR_BYTES);

    typedef struct packed {
        fsm_e              st;
        logic [PAGE_W-1:0] page;
        logic [OFF_W-1:0]  off;
        logic [LEN_W-1:0]  len;
        logic [PAGE_W-1:0] nxt_pg;
        logic [DW-1:0]     stat;
        logic [1:0]        hidx;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     wd;
    } frm_t;

    frm_t f_d, f_q;

    logic [PAGE_W-1:0] b_pg, adv_pg;
    logic [OFF_W-1:0]  b_off;
    logic [LEN_W-1:0]  b_len;
    logic              take;

    rxr_page_adv #(.PAGE_W(PAGE_W)) u_adv (
        .cur      (b_pg),
        .first    (first),
        .last_excl(last_excl),
        .nxt      (adv_pg)
    );

    always_comb begin
        f_d       = f_q;
        f_d.we    = 1'b0;
        ev_stored = 1'b0;
        ev_missed = 1'b0;
        ev_ovw    = 1'b0;
        curr_ld   = 1'b0;
        curr_nx   = f_q.nxt_pg;
        take      = 1'b0;

        if (f_q.st == ST_IDLE) begin
            b_pg  = curr;
            b_off = DATA_OFF;
            b_len = '0;
        end else begin
            b_pg  = f_q.page;
            b_off = f_q.off;
            b_len = f_q.len;
        end

        case (f_q.st)
            ST_IDLE: begin
                if (rx_valid) begin
                    if (mon || halted) begin
                        ev_missed = 1'b1;
                        f_d.st    = rx_last ? ST_IDLE : ST_DROP;
                    end else begin
                        take = 1'b1;
                    end
                end
            end
            ST_DATA: take = rx_valid;
            ST_DROP: if (rx_valid && rx_last) f_d.st = ST_IDLE;
            ST_HDR: begin
                f_d.we   = 1'b1;
                f_d.addr = {curr, OFF_W'(f_q.hidx)};
                case (f_q.hidx)
                    2'd0:    f_d.wd = f_q.stat;
                    2'd1:    f_d.wd = DW'(f_q.nxt_pg);
                    2'd2:    f_d.wd = f_q.len[7:0];
                    default: f_d.wd = f_q.len[15:8];
                endcase
                f_d.hidx = f_q.hidx + 1'b1;
                if (f_q.hidx == 2'd3) begin
                    f_d.st    = ST_IDLE;
                    curr_ld   = 1'b1;
                    ev_stored = 1'b1;
                end
            end
            default: f_d.st = ST_IDLE;
        endcase

        if (take) begin
            f_d.we   = 1'b1;
            f_d.addr = {b_pg, b_off};
            f_d.wd   = rx_data;
            f_d.len  = b_len + 1'b1;
            f_d.page = b_pg;
            if (rx_last) begin
                if (!rx_status[0]) begin
                    f_d.st = ST_IDLE;
                end else if (adv_pg == bndry) begin
                    ev_ovw = 1'b1;
                    f_d.st = ST_IDLE;
                end else begin
                    f_d.st     = ST_HDR;
                    f_d.nxt_pg = adv_pg;
                    f_d.stat   = rx_status;
                    f_d.len    = b_len + LEN_W'(HDR_BYTES + 1);
                    f_d.hidx   = '0;
                end
            end else if (&b_off) begin
                if (adv_pg == bndry) begin
                    ev_ovw = 1'b1;
                    f_d.st = ST_DROP;
                end else begin
                    f_d.st   = ST_DATA;
                    f_d.page = adv_pg;
                    f_d.off  = '0;
                end
            end else begin
                f_d.st  = ST_DATA;
                f_d.off = b_off + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q    <= '0;
            f_q.st <= ST_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign ram_we    = f_q.we;
    assign ram_addr  = f_q.addr;
    assign ram_wdata = f_q.wd;
endmodule

// File: rtl/rxring_mgr.sv
module rxring_mgr
    import rxr_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 8,
    parameter int LEN_W  = 16,
    parameter int MISS_W = 8,
    parameter logic [PAGE_W-1:0] FIRST_RST = 8'h46,
    parameter logic [PAGE_W-1:0] END_RST   = 8'h80
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [2:0]              reg_addr,
    input  logic [7:0]              reg_wdata,
    output logic [7:0]              reg_rdata,
    input  logic                    rx_valid,
    input  logic [7:0]              rx_data,
    input  logic                    rx_last,
    input  logic [7:0]              rx_status,
    output logic                    ram_we,
    output logic [PAGE_W+OFF_W-1:0] ram_addr,
    output logic [7:0]              ram_wdata
);
    logic [PAGE_W-1:0] first_w, end_w, bndry_w, curr_w, curr_nx_w;
    logic              mon_w, ev_stored_w, ev_missed_w, ev_ovw_w, curr_ld_w;
    logic [3:0]        flags_w;
    logic [MISS_W-1:0] miss_w;

    rxr_regs #(
        .PAGE_W(PAGE_W), .MISS_W(MISS_W),
        .FIRST_RST(FIRST_RST), .END_RST(END_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_stored(ev_stored_w), .ev_missed(ev_missed_w), .ev_ovw(ev_ovw_w),
        .curr_ld(curr_ld_w), .curr_nx(curr_nx_w),
        .first_o(first_w), .end_o(end_w), .bndry_o(bndry_w), .curr_o(curr_w),
        .mon_o(mon_w), .flags_o(flags_w), .miss_o(miss_w)
    );

    rxr_frame #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_status(rx_status),
        .first(first_w), .last_excl(end_w), .bndry(bndry_w), .curr(curr_w),
        .mon(mon_w), .halted(flags_w[3]),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ev_stored(ev_stored_w), .ev_missed(ev_missed_w), .ev_ovw(ev_ovw_w),
        .curr_ld(curr_ld_w), .curr_nx(curr_nx_w)
    );
endmodule

// File: rtl/rxr_chk.sv
module rxr_chk
    import rxr_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 8,
    parameter int MISS_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    reg_wr,
    input logic [2:0]              reg_addr,
    input logic                    ram_we,
    input logic [PAGE_W+OFF_W-1:0] ram_addr,
    input logic [PAGE_W-1:0]       first,
    input logic [PAGE_W-1:0]       last_excl,
    input logic [PAGE_W-1:0]       bndry,
    input logic [PAGE_W-1:0]       curr,
    input logic [3:0]              flags,
    input logic [MISS_W-1:0]       miss
);
    logic [PAGE_W-1:0] wr_pg;
    assign wr_pg = ram_addr[PAGE_W+OFF_W-1:OFF_W];

    // R3
    ring_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (wr_pg >= first && wr_pg < last_excl));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (wr_pg != bndry));

    // R5
    curr_after_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(curr) && !$past(reg_wr && reg_addr == A_CURR))
        |-> (ram_we && ram_addr[OFF_W-1:0] == OFF_W'(3)));

    // R8
    halt_with_ovw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[3]) |-> flags[2]);

    // R10
    miss_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_MISS) |=> (miss >= $past(miss)));
endmodule

bind rxring_mgr rxr_chk #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .MISS_W(MISS_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .ram_we(ram_we), .ram_addr(ram_addr),
    .first(first_w), .last_excl(end_w), .bndry(bndry_w), .curr(curr_w),
    .flags(flags_w), .miss(miss_w)
);

// File: tb/rxring_mgr_tb.sv
module rxring_mgr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic [7:0]  rx_status = '0;
    logic        ram_we;
    logic [15:0] ram_addr;
    logic [7:0]  ram_wdata;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    rxring_mgr dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last), .rx_status(rx_status),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
    );

    typedef struct packed {
        logic [15:0] a;
        logic [7:0]  d;
        logic [7:0]  r;
    } wr_item_t;
    wr_item_t exp_q[$];

    // reference state
    logic [7:0] m_first, m_end, m_bndry, m_curr, m_miss;
    bit m_halt, m_mon;

    function automatic logic [7:0] mnxt(logic [7:0] p);
        return (p + 8'd1 == m_end) ? m_first : p + 8'd1;
    endfunction

    task automatic push(logic [15:0] a, logic [7:0] d, logic [7:0] r);
        wr_item_t it;
        it.a = a; it.d = d; it.r = r;
        exp_q.push_back(it);
    endtask

    task automatic bump_miss();
        if (m_miss != 8'hFF) m_miss = m_miss + 8'd1;
    endtask

    // monitor: compare every RAM write with the scoreboard
    always @(negedge clk) begin
        if (rst_n && ram_we) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2/R4 unexpected write addr=%h data=%h expected none", ram_addr, ram_wdata);
            end else begin
                wr_item_t e;
                e = exp_q.pop_front();
                if (e.a !== ram_addr || e.d !== ram_wdata) begin
                    errors++;
                    $display("FAIL R%0d write addr=%h data=%h expected addr=%h data=%h",
                             e.r, ram_addr, ram_wdata, e.a, e.d);
                end
            end
        end
    end

    task automatic reg_write(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 3'd0) m_first = d;
        if (a == 3'd1) m_end = d;
        if (a == 3'd2) begin
            if (d != m_bndry) m_halt = 0;
            m_bndry = d;
        end
        if (a == 3'd3) m_curr = d;
        if (a == 3'd4) m_mon = d[0];
        if (a == 3'd6) m_miss = 8'd0;
    endtask

    task automatic chk_reg(logic [2:0] a, logic [7:0] exp, string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s reg %0d actual=%h expected=%h", req, a, reg_rdata, exp);
        end
    endtask

    task automatic send_frame(int len, logic [7:0] st, logic [7:0] seed, int gap);
        logic [7:0] pg, off, fp;
        bit drop;
        logic [15:0] cnt;
        drop = 0;
        if (m_mon || m_halt) begin
            bump_miss();
            drop = 1;
        end else begin
            pg = m_curr; off = 8'd4; fp = m_curr;
            for (int i = 0; i < len; i++) begin
                if (!drop) begin
                    push({pg, off}, seed + 8'(i), 8'd2);
                    if (i == len - 1) begin
                        if (!st[0]) begin
                        end else if (mnxt(pg) == m_bndry) begin
                            bump_miss(); m_halt = 1;
                        end else begin
                            cnt = 16'(len + 4);
                            push({fp, 8'd0}, st, 8'd4);
                            push({fp, 8'd1}, mnxt(pg), 8'd4);
                            push({fp, 8'd2}, cnt[7:0], 8'd4);
                            push({fp, 8'd3}, cnt[15:8], 8'd4);
                            m_curr = mnxt(pg);
                        end
                    end else if (off == 8'hFF) begin
                        if (mnxt(pg) == m_bndry) begin
                            bump_miss(); m_halt = 1; drop = 1;
                        end else begin
                            pg = mnxt(pg); off = 8'd0;
                        end
                    end else begin
                        off = off + 8'd1;
                    end
                end
            end
        end
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = seed + 8'(i);
            rx_last = (i == len - 1); rx_status = st;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_first = 8'h46; m_end = 8'h80; m_bndry = 8'h46; m_curr = 8'h47;
        m_miss = 0; m_halt = 0; m_mon = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        chk_reg(3'd0, 8'h46, "R1");
        chk_reg(3'd1, 8'h80, "R1");
        chk_reg(3'd2, 8'h46, "R1");
        chk_reg(3'd3, 8'h47, "R1");
        chk_reg(3'd4, 8'h00, "R1");
        chk_reg(3'd5, 8'h00, "R1");
        chk_reg(3'd6, 8'h00, "R1");
        chk_reg(3'd7, 8'h00, "R1");

        // small ring: pages 0x10..0x13
        reg_write(3'd0, 8'h10);
        reg_write(3'd1, 8'h14);
        reg_write(3'd2, 8'h10);
        reg_write(3'd3, 8'h11);

        // R2 R4 R5 short frame
        send_frame(60, 8'h01, 8'h20, 8);
        chk_reg(3'd3, 8'h12, "R5");
        chk_reg(3'd5, 8'h01, "R5");

        // R3 frame crossing a page and wrapping
        reg_write(3'd2, 8'h11);
        send_frame(300, 8'h01, 8'h55, 8);
        chk_reg(3'd3, 8'h10, "R3");

        // R6 bad frame
        send_frame(20, 8'h02, 8'h90, 8);
        chk_reg(3'd3, 8'h10, "R6");

        // R7 overflow at frame end
        send_frame(20, 8'h01, 8'hA0, 8);
        chk_reg(3'd5, 8'h0F, "R7");
        chk_reg(3'd6, 8'h01, "R7");
        chk_reg(3'd3, 8'h10, "R7");

        // R8 halted drops frames
        send_frame(10, 8'h01, 8'h30, 8);
        chk_reg(3'd6, 8'h02, "R8");
        reg_write(3'd2, 8'h13);
        chk_reg(3'd5, 8'h07, "R8");

        // R7 overflow while claiming a page mid-frame
        send_frame(800, 8'h01, 8'h07, 8);
        chk_reg(3'd3, 8'h10, "R7");
        chk_reg(3'd6, 8'h03, "R7");
        chk_reg(3'd5, 8'h0F, "R7");
        reg_write(3'd2, 8'h12);

        // R10 write-one-to-clear
        reg_write(3'd5, 8'h07);
        chk_reg(3'd5, 8'h00, "R10");

        // R4 header with a non-trivial status byte
        send_frame(30, 8'h21, 8'hC3, 8);
        chk_reg(3'd3, 8'h11, "R4");

        // R9 monitor mode
        reg_write(3'd4, 8'h01);
        chk_reg(3'd4, 8'h01, "R9");
        send_frame(20, 8'h01, 8'h11, 8);
        chk_reg(3'd6, 8'h04, "R9");
        chk_reg(3'd3, 8'h11, "R9");

        // R10 clear and saturation of the missed count
        reg_write(3'd6, 8'h00);
        chk_reg(3'd6, 8'h00, "R10");
        for (int k = 0; k < 260; k++) send_frame(1, 8'h01, 8'h00, 1);
        chk_reg(3'd6, 8'hFF, "R10");
        reg_write(3'd4, 8'h00);

        // R2 single-byte frame
        reg_write(3'd2, 8'h10);
        send_frame(1, 8'h01, 8'h77, 8);
        chk_reg(3'd3, 8'h12, "R2");

        repeat (10) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R4 missing writes actual=%0d expected=0", exp_q.size());
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule